// File: doc/BRIEF.md
# Flit Framer with Three-Way Interleaved Check Bytes

This block turns a plain byte stream into fixed 256-byte protected units. Payload bytes come in on a valid/ready byte port, and each one is forwarded as soon as the output register is free. After 242 payload bytes, the block appends a 64-bit CRC that covers those bytes. It then appends six forward-error-check bytes, taken from three codewords that interleave byte by byte. The output port is valid/ready, one byte per beat, and a marker flags byte 0 of every unit.

A receive-side checker sits in the same top module. It consumes a stream that carries the same unit layout, one byte per cycle whenever its valid input is high, and counts bytes from reset to find unit boundaries. It recomputes the CRC and both check bytes of each interleave. When the last byte of a unit arrives, it reports a CRC error flag and one error flag per interleave. It does not correct errors.

Top module: `flit_framer`

## Requirements
- R1: A unit is 256 output bytes. Bytes 0 to 241 are the accepted payload bytes, unchanged and in arrival order. `out_sof` is high only on byte 0.
- R2: Bytes 242 to 249 carry a CRC over the 242 payload bytes, most significant byte first. The CRC uses polynomial 0x42F0E1EBA9EA3693 with initial value 0. Each byte is fed most significant bit first, with no reflection and no final XOR.
- R3: Byte i of a unit belongs to interleave i mod 3. The check bytes of an interleave cover its payload and CRC bytes, which are unit bytes 0 to 249.
- R4: The parity byte of an interleave is the XOR of all the bytes it covers.
- R5: The weighted byte of an interleave is the GF(2^8) sum of b·α^k over its bytes. Here k = i div 3, α = 0x02, and the field polynomial is 0x11D.
- R6: Bytes 250 to 252 are the parity bytes of interleaves 0, 1 and 2. Bytes 253 to 255 are the weighted bytes of interleaves 0, 1 and 2.
- R7: `in_ready` stays low from the acceptance of payload byte 241 until byte 255 of the unit has been loaded into the output register.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_sof` hold their values. No byte is lost or repeated.
- R9: The cycle after the checker receives byte 255 of a unit, `rx_done` pulses high for one cycle. The error flags are valid in that cycle.
- R10: `rx_crc_err` is 1 when any received CRC byte differs from the CRC recomputed over the received payload.
- R11: Bit j of `rx_fec_err` is 1 when either received check byte of interleave j differs from the value recomputed over the received bytes 0 to 249 of that interleave.
- R12: A synchronous active-high reset makes `out_valid`, `out_sof` and `rx_done` low, returns both framer and checker to byte 0, and clears every accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Framer can take a payload byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output unit byte |
| out_sof | output | 1 | Marks byte 0 of a unit |
| out_ready | input | 1 | Downstream takes the output byte |
| rx_valid | input | 1 | Checker input byte valid |
| rx_data | input | 8 | Checker input byte |
| rx_done | output | 1 | One-cycle pulse after the last byte of a received unit |
| rx_crc_err | output | 1 | CRC mismatch on the unit just finished |
| rx_fec_err | output | 3 | Per-interleave check-byte mismatch |

## Verification
The assertions check, on every cycle, that the output holds under stall, that an accepted payload byte appears as the next output byte, that the start marker lasts exactly one beat, and that the done pulse is one cycle long. Only the bench scenarios can show that the CRC and the check-byte values are correct, and that they stay correct under random gaps and stalls. The same goes for the input port staying closed through the tail and for each error flag tracking the interleave that a corrupted byte falls into. A reset in the middle of a unit, followed by a clean unit, shows that the accumulators start fresh.

// File: rtl/flit_pkg.sv
package flit_pkg;
  localparam logic [7:0] GF_LOW = 8'h1D;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? GF_LOW : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ x;
      x = gf_xtime(x);
    end
    return acc;
  endfunction
endpackage

// File: rtl/flit_crc_acc.sv
module flit_crc_acc #(
  parameter int CRC_W = 64,
  parameter logic [CRC_W-1:0] CRC_POLY = 64'h42F0E1EBA9EA3693
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] nxt;

  always_comb begin
    nxt = crc;
    for (int b = 7; b >= 0; b--) begin
      if (nxt[CRC_W-1] ^ din[b]) nxt = {nxt[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                       nxt = {nxt[CRC_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc <= '0;
    else if (en)    crc <= nxt;
  end
endmodule

// File: rtl/flit_fec_acc.sv
module flit_fec_acc #(
  parameter int LANES = 3,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  en,
  input  logic [LW-1:0]         lane,
  input  logic [7:0]            din,
  output logic [LANES-1:0][7:0] par,
  output logic [LANES-1:0][7:0] wsum
);
  import flit_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] pw;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        par[g]  <= 8'h00;
        wsum[g] <= 8'h00;
        pw      <= 8'h01;
      end else if (en && lane == LW'(g)) begin
        par[g]  <= par[g] ^ din;
        wsum[g] <= wsum[g] ^ gf_mul(din, pw);
        pw      <= gf_xtime(pw);
      end
    end
  end
endmodule

// File: rtl/flit_tx.sv
module flit_tx #(
  parameter int PAY_BYTES = 242,
  parameter int CRC_W = 64,
  parameter logic [CRC_W-1:0] CRC_POLY = 64'h42F0E1EBA9EA3693,
  parameter int LANES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  input  logic       out_ready
);
  localparam int CRC_BYTES = CRC_W / 8;
  localparam int UNIT = PAY_BYTES + CRC_BYTES + 2 * LANES;
  localparam int CW = $clog2(UNIT);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [CW-1:0] cnt, tail_i, fec_i;
  logic [LW-1:0] lane;
  logic [CRC_W-1:0] crc_val, crc_sh;
  logic [LANES-1:0][7:0] par, wsum;
  logic [7:0] tx_byte;
  logic in_phase, prot_phase, adv, load, last;

  assign in_phase   = cnt < CW'(PAY_BYTES);
  assign prot_phase = cnt < CW'(PAY_BYTES + CRC_BYTES);
  assign adv        = !out_valid || out_ready;
  assign in_ready   = in_phase && adv;
  assign load       = adv && (in_phase ? in_valid : 1'b1);
  assign last       = cnt == CW'(UNIT - 1);
  assign tail_i     = cnt - CW'(PAY_BYTES);
  assign fec_i      = tail_i - CW'(CRC_BYTES);
  assign crc_sh     = crc_val << {tail_i, 3'b000};

  always_comb begin
    if (in_phase)                 tx_byte = in_data;
    else if (prot_phase)          tx_byte = crc_sh[CRC_W-1 -: 8];
    else if (fec_i < CW'(LANES))  tx_byte = par[fec_i[LW-1:0]];
    else                          tx_byte = wsum[LW'(fec_i - CW'(LANES))];
  end

  flit_crc_acc #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .clr(load && last), .en(load && in_phase),
    .din(tx_byte), .crc(crc_val));

  flit_fec_acc #(.LANES(LANES)) u_fec (
    .clk(clk), .rst(rst), .clr(load && last), .en(load && prot_phase),
    .lane(lane), .din(tx_byte), .par(par), .wsum(wsum));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      lane      <= '0;
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_sof   <= 1'b0;
    end else begin
      if (adv) begin
        out_valid <= load;
        out_sof   <= load && (cnt == '0);
        if (load) out_data <= tx_byte;
      end
      if (load) begin
        cnt <= last ? '0 : cnt + 1'b1;
        if (last) lane <= '0;
        else if (prot_phase) lane <= (lane == LW'(LANES - 1)) ? '0 : lane + 1'b1;
      end
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof));
  assert_payload_pass_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data));
  assert_sof_valid_R1: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
  assert_sof_single_R1: assert property (@(posedge clk) disable iff (rst)
    out_sof && out_ready |=> !out_sof);
endmodule

// File: rtl/flit_rx.sv
module flit_rx #(
  parameter int PAY_BYTES = 242,
  parameter int CRC_W = 64,
  parameter logic [CRC_W-1:0] CRC_POLY = 64'h42F0E1EBA9EA3693,
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_done,
  output logic             rx_crc_err,
  output logic [LANES-1:0] rx_fec_err
);
  localparam int CRC_BYTES = CRC_W / 8;
  localparam int UNIT = PAY_BYTES + CRC_BYTES + 2 * LANES;
  localparam int CW = $clog2(UNIT);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [CW-1:0] cnt, tail_i, fec_i;
  logic [LW-1:0] lane, chk_lane;
  logic [CRC_W-1:0] crc_val, crc_sh;
  logic [LANES-1:0][7:0] par, wsum;
  logic [7:0] want;
  logic in_phase, prot_phase, last, crc_bad;
  logic [LANES-1:0] fec_bad, fec_now;

  assign in_phase   = cnt < CW'(PAY_BYTES);
  assign prot_phase = cnt < CW'(PAY_BYTES + CRC_BYTES);
  assign last       = cnt == CW'(UNIT - 1);
  assign tail_i     = cnt - CW'(PAY_BYTES);
  assign fec_i      = tail_i - CW'(CRC_BYTES);
  assign crc_sh     = crc_val << {tail_i, 3'b000};

  always_comb begin
    if (fec_i < CW'(LANES)) begin
      chk_lane = fec_i[LW-1:0];
      want     = par[chk_lane];
    end else begin
      chk_lane = LW'(fec_i - CW'(LANES));
      want     = wsum[chk_lane];
    end
    fec_now = '0;
    if (!prot_phase && rx_data != want) fec_now[chk_lane] = 1'b1;
  end

  flit_crc_acc #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst(rst), .clr(rx_valid && last), .en(rx_valid && in_phase),
    .din(rx_data), .crc(crc_val));

  flit_fec_acc #(.LANES(LANES)) u_fec (
    .clk(clk), .rst(rst), .clr(rx_valid && last), .en(rx_valid && prot_phase),
    .lane(lane), .din(rx_data), .par(par), .wsum(wsum));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      lane       <= '0;
      crc_bad    <= 1'b0;
      fec_bad    <= '0;
      rx_done    <= 1'b0;
      rx_crc_err <= 1'b0;
      rx_fec_err <= '0;
    end else begin
      rx_done <= rx_valid && last;
      if (rx_valid) begin
        if (last) begin
          rx_crc_err <= crc_bad;
          rx_fec_err <= fec_bad | fec_now;
          crc_bad    <= 1'b0;
          fec_bad    <= '0;
          cnt        <= '0;
          lane       <= '0;
        end else begin
          cnt <= cnt + 1'b1;
          if (!in_phase && prot_phase && rx_data != crc_sh[CRC_W-1 -: 8]) crc_bad <= 1'b1;
          fec_bad <= fec_bad | fec_now;
          if (prot_phase) lane <= (lane == LW'(LANES - 1)) ? '0 : lane + 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> !rx_done);
endmodule

// File: rtl/flit_framer.sv
module flit_framer #(
  parameter int PAY_BYTES = 242,
  parameter int CRC_W = 64,
  parameter logic [CRC_W-1:0] CRC_POLY = 64'h42F0E1EBA9EA3693,
  parameter int LANES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  input  logic             out_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_done,
  output logic             rx_crc_err,
  output logic [LANES-1:0] rx_fec_err
);
  flit_tx #(.PAY_BYTES(PAY_BYTES), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .LANES(LANES)) u_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_ready(out_ready));

  flit_rx #(.PAY_BYTES(PAY_BYTES), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .LANES(LANES)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_done(rx_done),
    .rx_crc_err(rx_crc_err), .rx_fec_err(rx_fec_err));
endmodule

// File: tb/sim_flit_framer.sv
module sim_flit_framer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] in_data = 8'h00, rx_data = 8'h00;
  logic in_ready, out_valid, out_sof, rx_done, rx_crc_err;
  logic [7:0] out_data;
  logic [2:0] rx_fec_err;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] pay [242];
  logic [7:0] exp_b [256];

  always #2 clk = ~clk;

  flit_framer u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_ready(out_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_done(rx_done),
    .rx_crc_err(rx_crc_err), .rx_fec_err(rx_fec_err));

  function automatic logic [7:0] xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1D) : (a << 1);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    for (int k = 7; k >= 0; k--) r = xt(r) ^ (a[k] ? b : 8'h00);
    return r;
  endfunction

  task automatic build_exp();
    logic [63:0] c = 64'd0;
    logic [7:0] p [3];
    logic [7:0] w [3];
    logic [7:0] pw [3];
    for (int i = 0; i < 242; i++) begin
      c = c ^ {pay[i], 56'd0};
      for (int s = 0; s < 8; s++) c = c[63] ? ((c << 1) ^ 64'h42F0E1EBA9EA3693) : (c << 1);
      exp_b[i] = pay[i];
    end
    for (int j = 0; j < 8; j++) exp_b[242 + j] = c[63 - 8*j -: 8];
    for (int l = 0; l < 3; l++) begin p[l] = 0; w[l] = 0; pw[l] = 1; end
    for (int i = 0; i < 250; i++) begin
      p[i % 3]  = p[i % 3] ^ exp_b[i];
      w[i % 3]  = w[i % 3] ^ gmul(exp_b[i], pw[i % 3]);
      pw[i % 3] = xt(pw[i % 3]);
    end
    for (int l = 0; l < 3; l++) begin exp_b[250 + l] = p[l]; exp_b[253 + l] = w[l]; end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic string region(input int i);
    if (i < 242) return "R1 payload";
    if (i < 250) return "R2 crc byte";
    if (i < 253) return "R4 R6 parity byte";
    return "R5 R6 weighted byte";
  endfunction

  // cpos < 0 means no corruption on the checker path
  task automatic run_unit(input int pv, input int pr, input int cpos, input logic [7:0] cmask);
    int sent = 0, got = 0, cyc = 0;
    bit done = 0, tail_open = 0;
    logic ecrc;
    logic [2:0] efec;
    build_exp();
    ecrc = (cpos >= 0) && (cpos < 250);
    efec = 3'b000;
    if (cpos >= 0) efec[(cpos < 250) ? cpos % 3 : (cpos - 250) % 3] = 1'b1;
    while (!done) begin
      @(negedge clk);
      in_valid = (sent < 242) && (($urandom % 100) < pv);
      in_data  = (sent < 242) ? pay[sent] : 8'h00;
      out_ready = ($urandom % 100) < pr;
      #1;
      if (sent == 242 && got < 255 && in_ready) tail_open = 1;
      if (in_valid && in_ready) sent++;
      if (out_valid && out_ready) begin
        chk(out_data == exp_b[got], region(got), out_data, exp_b[got]);
        chk(out_sof == (got == 0), "R1 sof marker", out_sof, got == 0);
        rx_valid = 1'b1;
        rx_data  = out_data ^ ((got == cpos) ? cmask : 8'h00);
        got++;
      end else rx_valid = 1'b0;
      if (rx_done) begin
        chk(rx_crc_err == ecrc, "R10 R9 crc flag", rx_crc_err, ecrc);
        chk(rx_fec_err == efec, "R11 R3 R9 interleave flags", rx_fec_err, efec);
        done = 1;
      end
      cyc++;
      if (cyc > 20000) begin
        chk(0, "watchdog", got, 256);
        done = 1;
      end
    end
    chk(!tail_open, "R7 in_ready low through tail", tail_open, 0);
    chk(got == 256, "R8 byte count", got, 256);
  endtask

  task automatic fill_rand();
    for (int i = 0; i < 242; i++) pay[i] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!out_valid && !out_sof, "R12 reset out_valid", out_valid, 0);
    chk(!rx_done, "R12 reset rx_done", rx_done, 0);
    chk(in_ready, "R12 reset in_ready", in_ready, 1);

    for (int i = 0; i < 242; i++) pay[i] = 8'h00;
    run_unit(100, 100, -1, 8'h00);
    for (int i = 0; i < 242; i++) pay[i] = 8'hFF;
    run_unit(100, 100, -1, 8'h00);
    fill_rand(); run_unit(60, 50, -1, 8'h00);
    fill_rand(); run_unit(100, 100, 7, 8'h01);    // payload byte, lane 1
    fill_rand(); run_unit(70, 80, 245, 8'h80);    // crc byte, lane 2
    fill_rand(); run_unit(90, 40, 254, 8'h10);    // weighted byte of lane 1
    fill_rand(); run_unit(50, 90, 252, 8'h03);    // parity byte of lane 2

    // R12: reset in the middle of a unit, then a clean unit must match
    fill_rand();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pay[i]; out_ready = 1'b1; rx_valid = 1'b1; rx_data = 8'h5A;
    end
    @(negedge clk);
    in_valid = 1'b0; rx_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid && !rx_done, "R12 mid-unit reset", out_valid, 0);
    fill_rand(); run_unit(80, 70, -1, 8'h00);

    for (int u = 0; u < 4; u++) begin
      fill_rand();
      run_unit(30 + 20*u, 100 - 15*u, (u % 2) ? int'($urandom % 256) : -1, 8'h40);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule